// File: doc/BRIEF.md
# Add-Compare-Select Path Metric Unit with Noise Monitor

This block is the path metric stage of a hard- or soft-decision decoder for a rate 1/2 convolutional code. The code has constraint length 4, so the trellis has 8 states. The code generators are 15 and 17 octal.

Each time a symbol is presented, the unit takes four branch metrics, one for each two-bit code symbol. For every trellis state it adds the two incoming branch metrics to the stored metrics of the two predecessor states. It keeps the smaller sum and emits one survivor bit per state, which the traceback stage stores. It also reports which state now holds the smallest metric, and that metric's value.

The accumulators never wrap. A common offset is removed from all eight metrics once every one of them has reached the upper half of the range. A side counter gives a rough estimate of channel noise. It counts how many quarter-range boundaries one chosen state's metric climbs past. The climb is measured against that metric's value after any normalization, so the offset removal itself never registers as a crossing.

Top module: `vit_pmu`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `dec_valid`, `norm_evt`, `dec_bits`, `best_state`, `best_metric` and `noise_cnt` are all 0. Reset loads state 0 with metric 0 and every other state with 2^(PM_W-2).
- R2: The state register is a shift register whose top bit (bit 2) holds the newest input bit. State s therefore has predecessors p0 = {s[1:0],0} and p1 = {s[1:0],1}.
  - The encoder window is the 4-bit value {s[2], p}. The symbol index is {c0,c1}, where c0 is the parity of (window AND 15 octal) and c1 is the parity of (window AND 17 octal).
  - The branch metric for symbol index j sits at bits `bm_flat[j*BM_W +: BM_W]`.
  - The new metric of s is the smaller of pm[p0]+bm(p0→s) and pm[p1]+bm(p1→s).
- R3: `dec_bits[s]` is 1 exactly when the candidate from p1 is strictly smaller. On a tie the bit is 0, meaning the lower-numbered predecessor was kept.
- R4: `best_state` is the lowest-numbered state among those holding the smallest updated metric, and `best_metric` is that metric.
- R5: If all eight stored metrics have their top bit set when a symbol arrives, 2^(PM_W-1) is subtracted from each before the additions. `norm_evt` is 1 for that update.
- R6: No candidate sum ever exceeds 2^PM_W - 1. The reported metrics therefore never wrap.
- R7: On each update, `noise_cnt` grows by the number of quarter-range boundaries (multiples of 2^(PM_W-2)) that the monitored state's new metric lies above its normalized previous metric. A drop adds nothing.
- R8: `noise_cnt` saturates at its all-ones value and stays there.
- R9: Results appear on the outputs one clock after a cycle with `sym_valid` high. `dec_valid` and `norm_evt` are single-cycle pulses. Without `sym_valid` the metrics, `dec_bits`, `best_state`, `best_metric` and `noise_cnt` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A set of branch metrics is present |
| bm_flat | input | 4*BM_W | Branch metrics, indexed by the code symbol {c0,c1} |
| dec_valid | output | 1 | Survivor bits are valid this cycle |
| dec_bits | output | 8 | One survivor bit per state |
| best_state | output | 3 | Index of the state with the smallest metric |
| best_metric | output | PM_W | Value of that smallest metric |
| norm_evt | output | 1 | This update removed the common offset |
| noise_cnt | output | NOISE_W | Saturating count of upward threshold crossings |

## Verification
The bench sweeps all 4096 combinations of four 3-bit branch metrics starting from reset. After the sweep it applies a long run of uniform maximal metrics, and it compares every update against an arithmetic model of the trellis.

- The uniform run makes all metrics equal, so every state faces a tie. A design that preferred the odd predecessor on ties would show set survivor bits there, and a wrong minimum scan would report a higher state index.
- The same run forces repeated normalization. A design that normalized late would overflow and wrap `best_metric`, while one that compared the monitored metric against its raw previous value would lose crossings or count spurious ones.
- The run also drives the noise counter into saturation, where a wrapping counter would fall back to small values.
- Idle gaps are inserted to show that results hold and that the valid pulse does not linger.

// File: rtl/vit_pmu_pkg.sv
package vit_pmu_pkg;

  // Two-bit code symbol {c0,c1} for one encoder window (newest bit at top).
  function automatic logic [1:0] code_sym(input logic [31:0] win,
                                          input logic [31:0] g0,
                                          input logic [31:0] g1);
    return {^(win & g0), ^(win & g1)};
  endfunction

  // Number of distinct code symbols of a rate 1/2 code.
  localparam int NUM_SYM = 4;

endpackage

// File: rtl/vit_acs_node.sv
module vit_acs_node #(
  parameter int BM_W = 3,
  parameter int PM_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PM_W-1:0] pm_lo,
  input  logic [PM_W-1:0] pm_hi,
  input  logic [BM_W-1:0] bm_lo,
  input  logic [BM_W-1:0] bm_hi,
  output logic [PM_W-1:0] pm_sel,
  output logic            pick_hi
);

  logic [PM_W:0] cand_lo;
  logic [PM_W:0] cand_hi;

  always_comb begin
    cand_lo = {1'b0, pm_lo} + {{(PM_W+1-BM_W){1'b0}}, bm_lo};
    cand_hi = {1'b0, pm_hi} + {{(PM_W+1-BM_W){1'b0}}, bm_hi};
    // Strict compare: a tie keeps the lower-numbered predecessor.
    pick_hi = (cand_hi < cand_lo);
    pm_sel  = pick_hi ? cand_hi[PM_W-1:0] : cand_lo[PM_W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    en |-> (!cand_lo[PM_W] && !cand_hi[PM_W])); // R6

endmodule

// File: rtl/vit_best_sel.sv
module vit_best_sel #(
  parameter int NS   = 8,
  parameter int PM_W = 10,
  localparam int IW  = $clog2(NS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PM_W-1:0] metric [NS],
  output logic [IW-1:0]   best_idx,
  output logic [PM_W-1:0] best_val
);

  always_comb begin
    best_idx = '0;
    best_val = metric[0];
    for (int i = 1; i < NS; i++) begin
      if (metric[i] < best_val) begin
        best_idx = IW'(i);
        best_val = metric[i];
      end
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_chk
    AST_BEST_IS_MIN: assert property (@(posedge clk) disable iff (rst)
      best_val <= metric[g]); // R4
    AST_BEST_LOWEST: assert property (@(posedge clk) disable iff (rst)
      (metric[g] == best_val) |-> (IW'(g) >= best_idx)); // R4
  end

endmodule

// File: rtl/vit_noise_mon.sv
module vit_noise_mon #(
  parameter int NOISE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [1:0]         lvl_prev,
  input  logic [1:0]         lvl_next,
  output logic [NOISE_W-1:0] cnt
);

  logic [1:0]       rise;
  logic [NOISE_W:0] sum;

  always_comb begin
    rise = (lvl_next > lvl_prev) ? (lvl_next - lvl_prev) : 2'd0;
    sum  = {1'b0, cnt} + {{(NOISE_W-1){1'b0}}, rise};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= sum[NOISE_W] ? {NOISE_W{1'b1}} : sum[NOISE_W-1:0];
    end
  end

  AST_NOISE_MONO: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt >= $past(cnt))); // R7
  AST_NOISE_SAT: assert property (@(posedge clk) disable iff (rst)
    (cnt == {NOISE_W{1'b1}}) |=> (cnt == {NOISE_W{1'b1}})); // R8
  AST_NOISE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R9

endmodule

// File: rtl/vit_pmu.sv
module vit_pmu #(
  parameter int          K         = 4,
  parameter logic [31:0] G0        = 32'o15,
  parameter logic [31:0] G1        = 32'o17,
  parameter int          BM_W      = 3,
  parameter int          PM_W      = 10,
  parameter int          NOISE_W   = 8,
  parameter int          MON_STATE = 0,
  localparam int         NS        = 2 ** (K - 1),
  localparam int         SW        = K - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sym_valid,
  input  logic [4*BM_W-1:0]    bm_flat,
  output logic                 dec_valid,
  output logic [NS-1:0]        dec_bits,
  output logic [SW-1:0]        best_state,
  output logic [PM_W-1:0]      best_metric,
  output logic                 norm_evt,
  output logic [NOISE_W-1:0]   noise_cnt
);
  import vit_pmu_pkg::*;

  localparam logic [PM_W-1:0] INIT_HI = PM_W'(2 ** (PM_W - 2));

  logic [BM_W-1:0] bm      [NUM_SYM];
  logic [PM_W-1:0] pm_q    [NS];
  logic [PM_W-1:0] pm_n    [NS];
  logic [PM_W-1:0] pm_next [NS];
  logic [NS-1:0]   msb_vec;
  logic [NS-1:0]   dec_next;
  logic            norm_all;
  logic [SW-1:0]   best_idx_c;
  logic [PM_W-1:0] best_val_c;

  for (genvar j = 0; j < NUM_SYM; j++) begin : g_bm
    assign bm[j] = bm_flat[j*BM_W +: BM_W];
  end

  // Normalization: clear the top bit of every metric once all have it set.
  for (genvar i = 0; i < NS; i++) begin : g_norm
    assign msb_vec[i] = pm_q[i][PM_W-1];
    assign pm_n[i]    = norm_all ? {1'b0, pm_q[i][PM_W-2:0]} : pm_q[i];
  end
  assign norm_all = &msb_vec;

  // One ACS node per state; predecessors {s[1:0],0} and {s[1:0],1}.
  for (genvar s = 0; s < NS; s++) begin : g_state
    localparam int          P_LO  = (s * 2) % NS;
    localparam int          P_HI  = P_LO + 1;
    localparam int          U_BIT = s / (NS / 2);
    localparam logic [31:0] W_LO  = 32'(U_BIT * NS + P_LO);
    localparam logic [31:0] W_HI  = 32'(U_BIT * NS + P_HI);
    localparam logic [1:0]  S_LO  = code_sym(W_LO, G0, G1);
    localparam logic [1:0]  S_HI  = code_sym(W_HI, G0, G1);

    vit_acs_node #(.BM_W(BM_W), .PM_W(PM_W)) u_acs (
      .clk     (clk),
      .rst     (rst),
      .en      (sym_valid),
      .pm_lo   (pm_n[P_LO]),
      .pm_hi   (pm_n[P_HI]),
      .bm_lo   (bm[S_LO]),
      .bm_hi   (bm[S_HI]),
      .pm_sel  (pm_next[s]),
      .pick_hi (dec_next[s])
    );
  end

  vit_best_sel #(.NS(NS), .PM_W(PM_W)) u_best (
    .clk      (clk),
    .rst      (rst),
    .metric   (pm_next),
    .best_idx (best_idx_c),
    .best_val (best_val_c)
  );

  vit_noise_mon #(.NOISE_W(NOISE_W)) u_noise (
    .clk      (clk),
    .rst      (rst),
    .step     (sym_valid),
    .lvl_prev (pm_n[MON_STATE][PM_W-1:PM_W-2]),
    .lvl_next (pm_next[MON_STATE][PM_W-1:PM_W-2]),
    .cnt      (noise_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        pm_q[i] <= (i == 0) ? '0 : INIT_HI;
      end
      dec_valid   <= 1'b0;
      norm_evt    <= 1'b0;
      dec_bits    <= '0;
      best_state  <= '0;
      best_metric <= '0;
    end else begin
      dec_valid <= sym_valid;
      norm_evt  <= sym_valid & norm_all;
      if (sym_valid) begin
        for (int i = 0; i < NS; i++) begin
          pm_q[i] <= pm_next[i];
        end
        dec_bits    <= dec_next;
        best_state  <= best_idx_c;
        best_metric <= best_val_c;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!dec_valid && !norm_evt && noise_cnt == '0)); // R1
  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(sym_valid)); // R9
  AST_NORM_IN_STEP: assert property (@(posedge clk) disable iff (rst)
    norm_evt |-> dec_valid); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> ($stable(best_metric) && $stable(dec_bits) && $stable(best_state))); // R9
  AST_NORM_DROPS: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && norm_all) |=> (best_metric < $past(best_metric))); // R5

endmodule

// File: tb/test_vit_pmu.sv
`timescale 1ns/1ps
module test_vit_pmu;

  localparam int BM_W = 3;
  localparam int PM_W = 10;
  localparam int NW   = 8;
  localparam int NS   = 8;
  localparam int HALF = 2 ** (PM_W - 1);
  localparam int QTR  = 2 ** (PM_W - 2);
  localparam int NMAX = 2 ** NW - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sym_valid = 1'b0;
  logic [4*BM_W-1:0] bm_flat = '0;
  logic              dec_valid;
  logic [NS-1:0]     dec_bits;
  logic [2:0]        best_state;
  logic [PM_W-1:0]   best_metric;
  logic              norm_evt;
  logic [NW-1:0]     noise_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int ref_pm [NS];
  int ref_noise;
  int ref_dec, ref_best, ref_bval, ref_norm;
  int norms_seen = 0;

  always #2.5 clk = ~clk;

  vit_pmu i_vit_pmu (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .bm_flat(bm_flat),
    .dec_valid(dec_valid), .dec_bits(dec_bits), .best_state(best_state),
    .best_metric(best_metric), .norm_evt(norm_evt), .noise_cnt(noise_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int parity(input int v);
    int p = 0;
    for (int b = 0; b < 8; b++) p ^= (v >> b) & 1;
    return p;
  endfunction

  // Reference trellis step from the requirements.
  function automatic void model_step(input int b [4]);
    int pmn [NS];
    int nxt [NS];
    bit all_hi = 1'b1;
    for (int i = 0; i < NS; i++) if (ref_pm[i] < HALF) all_hi = 1'b0;
    for (int i = 0; i < NS; i++) pmn[i] = all_hi ? ref_pm[i] - HALF : ref_pm[i];
    ref_norm = all_hi;
    ref_dec = 0;
    for (int s = 0; s < NS; s++) begin
      int p0 = (s & 3) << 1;
      int p1 = p0 | 1;
      int u  = s >> 2;
      int w0 = (u << 3) | p0;
      int w1 = (u << 3) | p1;
      int c0 = pmn[p0] + b[parity(w0 & 'o15) * 2 + parity(w0 & 'o17)];
      int c1 = pmn[p1] + b[parity(w1 & 'o15) * 2 + parity(w1 & 'o17)];
      if (c1 < c0) begin nxt[s] = c1; ref_dec |= (1 << s); end
      else nxt[s] = c0;
    end
    ref_best = 0; ref_bval = nxt[0];
    for (int s = 1; s < NS; s++) if (nxt[s] < ref_bval) begin ref_best = s; ref_bval = nxt[s]; end
    if ((nxt[0] / QTR) > (pmn[0] / QTR)) begin
      ref_noise += (nxt[0] / QTR) - (pmn[0] / QTR);
      if (ref_noise > NMAX) ref_noise = NMAX;
    end
    for (int s = 0; s < NS; s++) ref_pm[s] = nxt[s];
  endfunction

  task automatic step(input int b [4]);
    bm_flat   = {BM_W'(b[3]), BM_W'(b[2]), BM_W'(b[1]), BM_W'(b[0])};
    sym_valid = 1'b1;
    model_step(b);
    @(negedge clk);
    sym_valid = 1'b0;
    if (ref_norm) norms_seen++;
    chk(dec_valid == 1'b1, "R9 valid pulse", dec_valid, 1);
    chk(dec_bits == NS'(ref_dec), "R2/R3 survivor bits", dec_bits, ref_dec);
    chk(best_state == 3'(ref_best), "R4 best state", best_state, ref_best);
    chk(best_metric == PM_W'(ref_bval) && ref_bval < 2 ** PM_W, "R6 best metric", best_metric, ref_bval);
    chk(norm_evt == ref_norm[0], "R5 normalization flag", norm_evt, ref_norm);
    chk(noise_cnt == NW'(ref_noise), "R7 noise count", noise_cnt, ref_noise);
  endtask

  task automatic idle_check();
    logic [PM_W-1:0] m = best_metric;
    logic [NS-1:0]   d = dec_bits;
    logic [NW-1:0]   n = noise_cnt;
    repeat (3) @(negedge clk);
    chk(dec_valid == 1'b0, "R9 pulse ends", dec_valid, 0);
    chk(norm_evt == 1'b0, "R9 norm pulse ends", norm_evt, 0);
    chk(best_metric == m && dec_bits == d && noise_cnt == n, "R9 hold while idle", best_metric, m);
  endtask

  initial begin
    int b [4];
    for (int i = 0; i < NS; i++) ref_pm[i] = (i == 0) ? 0 : QTR;
    ref_noise = 0;
    repeat (3) @(negedge clk);
    chk(dec_valid == 0 && norm_evt == 0, "R1 reset pulses", dec_valid, 0);
    chk(best_metric == 0 && best_state == 0, "R1 reset best", best_metric, 0);
    chk(noise_cnt == 0 && dec_bits == 0, "R1 reset noise", noise_cnt, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dec_valid == 0 && noise_cnt == 0 && best_metric == 0, "R1 after reset", best_metric, 0);
    // R1 initial metrics: all-zero branch metrics expose state 0 at 0, others at QTR.
    b = '{0, 0, 0, 0};
    step(b);
    chk(ref_bval == 0, "R1 state 0 starts at zero", best_metric, 0);
    // Exhaustive sweep of the four branch metrics (R2, R3, R4).
    for (int a = 0; a < 4096; a++) begin
      b = '{a & 7, (a >> 3) & 7, (a >> 6) & 7, (a >> 9) & 7};
      step(b);
      if ((a % 512) == 511) idle_check();
    end
    // Uniform maximal metrics: ties, repeated normalization, saturation (R3, R5, R8).
    for (int t = 0; t < 12000; t++) begin
      b = '{7, 7, 7, 7};
      step(b);
      if (t > 10) chk(dec_bits == 0, "R3 tie keeps lower predecessor", dec_bits, 0);
    end
    chk(norms_seen > 10, "R5 normalization occurred", norms_seen, 11);
    chk(noise_cnt == NW'(NMAX), "R8 noise saturated", noise_cnt, NMAX);
    b = '{7, 7, 7, 7};
    step(b);
    chk(noise_cnt == NW'(NMAX), "R8 saturation holds", noise_cnt, NMAX);
    idle_check();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule